// File: doc/BRIEF.md
# Fuse array programming sequencer

This block drives the fusing of the AND-plane in a fuse-programmable logic array. It works through the product terms one after another. For each used term it reads one pattern word from an external memory. It then takes each input variable in turn and burns the link or links that the term's literal calls for. No analog levels come out of the block. Every pin of the device under programming is described by a small level code on a registered command bus, and external drivers turn those codes into voltages.

A host pulses `start` while the sequencer is idle. `busy` then stays high for the whole job. When the last term is finished, the sequencer releases every drive and raises `done` for one cycle. All waits are counted in clock cycles by one down-counter: `T_D` for the settle delay and `T_P` for the width of the chip-enable pulse. Checking the fuses afterwards and rejecting parts are left to other logic.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset and whenever not busy, every input code, `fe_drv` and `ce_drv` read 2'b11 (released), `supply_en` is 0, and `busy` and `done` are 0 (level codes: 00 low, 01 high, 10 intermediate, 11 released).
- R2: A `start` seen while idle makes, on the next cycle, `busy`=1, `supply_en`=1, `ce_drv`=01 (outputs disabled), `fe_drv`=00 and every input code 10.
- R3: Terms are visited in ascending order from 0 to N_TERMS-1. Each term is read exactly once, with `pat_rd` high and `pat_addr` set to the term number. The word is taken from `pat_data` one cycle later, and `term_sel` carries the term number (bit 0 is the LSB) while its links are burned.
- R4: Pattern word layout: bit 2*N_INPUTS is the used flag, and bits [2i+1:2i] hold the literal of input i. A term whose used flag is 0 gets no chip-enable pulse.
- R5: For a used term, a literal 01 (true) or 10 (complement) drives that input to 00 and burns one link. A literal 00 or 11 (don't care) burns two links one after the other, and the input stays at 00 in between.
- R6: Within a term the inputs are handled from I0 upward, and at most one input code is 00 at any time. An input goes back to 10 in the same cycle that `fe_drv` falls after its last burn.
- R7: Each burn follows one schedule. `fe_drv` goes 00→01 T_D cycles after the input went low, or T_D cycles after the previous `fe_drv` fall. `ce_drv` reads 10 from T_D cycles after that rise, for exactly T_P cycles. `fe_drv` returns to 00 T_D cycles after `ce_drv` is back at 01.
- R8: While busy, `ce_drv` is only ever 01 or 10, `fe_drv` is only ever 00 or 01, and `ce_drv`=10 only while `fe_drv`=01.
- R9: After the last term, `done` is high for exactly one cycle. In that cycle `busy` is 0 and every drive is already released as in R1.
- R10: A `start` pulse while busy is ignored: the job is not restarted and finishes with a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a job when idle |
| busy | output | 1 | High during a job |
| done | output | 1 | One-cycle end-of-job pulse |
| pat_rd | output | 1 | Pattern memory read strobe |
| pat_addr | output | $clog2(N_TERMS) | Pattern memory address (term number) |
| pat_data | input | 2*N_INPUTS+1 | Pattern word, valid the cycle after `pat_rd` |
| supply_en | output | 1 | Programming supply enable |
| term_sel | output | $clog2(N_TERMS) | Term address driven on the device outputs |
| fe_drv | output | 2 | Fuse-enable level code |
| ce_drv | output | 2 | Chip-enable level code |
| in_drv | output | 2*N_INPUTS | Level code per input, input i at [2i+1:2i] |

## Verification
If the stored pattern word, the input index or the term counter goes wrong, the chip-enable pulses land on the wrong (term, input) pair or come in the wrong number. That shows up at the first burn of the affected input, a few T_D cycles after the error. A fault in the wait counter shows up in the very next phase, as a fuse-enable or chip-enable edge that arrives early or late. A fault in the end-of-job path shows up only at the final `done`, as inputs that are not released or as extra pattern reads.

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq #(
  parameter int N_TERMS  = 48,
  parameter int N_INPUTS = 16,
  parameter int T_D      = 3,
  parameter int T_P      = 2,
  localparam int AW = $clog2(N_TERMS),
  localparam int IW = $clog2(N_INPUTS),
  localparam int WW = 2*N_INPUTS + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic                  pat_rd,
  output logic [AW-1:0]         pat_addr,
  input  logic [WW-1:0]         pat_data,
  output logic                  supply_en,
  output logic [AW-1:0]         term_sel,
  output logic [1:0]            fe_drv,
  output logic [1:0]            ce_drv,
  output logic [2*N_INPUTS-1:0] in_drv
);
  localparam int TMAX = (T_D > T_P) ? T_D : T_P;
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [1:0] LV_LO = 2'b00, LV_HI = 2'b01, LV_MID = 2'b10, LV_REL = 2'b11;

  typedef enum logic [3:0] {
    S_IDLE, S_READ, S_CAP, S_LOWER, S_WFE, S_WCE, S_PULSE, S_WOFF, S_FIN
  } state_t;

  state_t          state;
  logic [AW-1:0]   term;
  logic [IW-1:0]   idx;
  logic [CW-1:0]   cnt;
  logic [WW-1:0]   word;
  logic            second;
  logic [1:0]      lit;

  wire cnt_zero  = (cnt == '0);
  wire last_in   = (idx == IW'(N_INPUTS-1));
  wire last_term = (term == AW'(N_TERMS-1));

  assign lit      = word[2*idx +: 2];
  assign pat_rd   = (state == S_READ);
  assign pat_addr = term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      supply_en <= 1'b0;
      term_sel  <= '0;
      fe_drv    <= LV_REL;
      ce_drv    <= LV_REL;
      in_drv    <= '1;
      term      <= '0;
      idx       <= '0;
      cnt       <= '0;
      word      <= '0;
      second    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          busy      <= 1'b1;
          supply_en <= 1'b1;
          ce_drv    <= LV_HI;
          fe_drv    <= LV_LO;
          in_drv    <= {N_INPUTS{LV_MID}};
          term      <= '0;
          state     <= S_READ;
        end
        S_READ: begin
          term_sel <= term;
          state    <= S_CAP;
        end
        S_CAP: begin
          word <= pat_data;
          idx  <= '0;
          if (pat_data[WW-1]) state <= S_LOWER;
          else if (last_term) state <= S_FIN;
          else begin
            term  <= term + AW'(1);
            state <= S_READ;
          end
        end
        S_LOWER: begin
          in_drv[2*idx +: 2] <= LV_LO;
          second <= !(lit == 2'b01 || lit == 2'b10);
          cnt    <= CW'(T_D-1);
          state  <= S_WFE;
        end
        S_WFE:
          if (cnt_zero) begin
            fe_drv <= LV_HI;
            cnt    <= CW'(T_D-1);
            state  <= S_WCE;
          end else cnt <= cnt - CW'(1);
        S_WCE:
          if (cnt_zero) begin
            ce_drv <= LV_MID;
            cnt    <= CW'(T_P-1);
            state  <= S_PULSE;
          end else cnt <= cnt - CW'(1);
        S_PULSE:
          if (cnt_zero) begin
            ce_drv <= LV_HI;
            cnt    <= CW'(T_D-1);
            state  <= S_WOFF;
          end else cnt <= cnt - CW'(1);
        S_WOFF:
          if (cnt_zero) begin
            fe_drv <= LV_LO;
            if (second) begin
              second <= 1'b0;
              cnt    <= CW'(T_D-1);
              state  <= S_WFE;
            end else begin
              in_drv[2*idx +: 2] <= LV_MID;
              if (!last_in) begin
                idx   <= idx + IW'(1);
                state <= S_LOWER;
              end else if (last_term) state <= S_FIN;
              else begin
                term  <= term + AW'(1);
                state <= S_READ;
              end
            end
          end else cnt <= cnt - CW'(1);
        S_FIN: begin
          in_drv    <= '1;
          fe_drv    <= LV_REL;
          ce_drv    <= LV_REL;
          supply_en <= 1'b0;
          busy      <= 1'b0;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fuse_prog_seq_chk.sv
module fuse_prog_seq_chk #(
  parameter int N_INPUTS = 16,
  parameter int T_P      = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic                  supply_en,
  input logic [1:0]            fe_drv,
  input logic [1:0]            ce_drv,
  input logic [2*N_INPUTS-1:0] in_drv
);
  int nlow;
  int pw;

  always_comb begin
    nlow = 0;
    for (int i = 0; i < N_INPUTS; i++)
      if (in_drv[2*i +: 2] == 2'b00) nlow = nlow + 1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pw <= 0;
    else pw <= (ce_drv == 2'b10) ? pw + 1 : 0;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (in_drv == '1 && fe_drv == 2'b11 && ce_drv == 2'b11 && !supply_en)); // R1
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && supply_en && ce_drv == 2'b01 && fe_drv == 2'b00)); // R2
  AST_SINGLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> nlow <= 1); // R6
  AST_CE_INSIDE_FE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_drv == 2'b10) |-> (fe_drv == 2'b01)); // R8
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (pw != 0 && ce_drv != 2'b10) |-> pw == T_P); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && in_drv == '1)); // R9
endmodule

bind fuse_prog_seq fuse_prog_seq_chk #(.N_INPUTS(N_INPUTS), .T_P(T_P)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .supply_en(supply_en), .fe_drv(fe_drv), .ce_drv(ce_drv), .in_drv(in_drv)
);

// File: tb/fuse_prog_seq_test.sv
module fuse_prog_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 48;
  localparam int NI = 16;
  localparam int TD = 3;
  localparam int TP = 2;
  localparam int AW = $clog2(NT);
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, pat_rd, supply_en;
  logic [AW-1:0] pat_addr, term_sel;
  logic [2*NI:0] pat_data;
  logic [1:0] fe_drv, ce_drv;
  logic [2*NI-1:0] in_drv;

  logic [2*NI:0] mem [NT];
  int checks = 0, fails = 0;
  int cyc = 0;
  bit wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) if (pat_rd) pat_data <= mem[pat_addr];

  fuse_prog_seq #(.N_TERMS(NT), .N_INPUTS(NI), .T_D(TD), .T_P(TP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pat_rd(pat_rd), .pat_addr(pat_addr), .pat_data(pat_data),
    .supply_en(supply_en), .term_sel(term_sel), .fe_drv(fe_drv),
    .ce_drv(ce_drv), .in_drv(in_drv)
  );

  function automatic int exp_blows(logic [2*NI:0] w, int i);
    logic [1:0] c = w[2*i +: 2];
    if (!w[2*NI]) return 0;
    return (c == 2'b01 || c == 2'b10) ? 1 : 2;
  endfunction

  function automatic logic [2*NI:0] gen_word(int mode, int t);
    logic [2*NI:0] w;
    for (int i = 0; i < NI; i++)
      case (mode)
        0: w[2*i +: 2] = (i % 5 == 0) ? 2'b11 : 2'b00;
        3: w[2*i +: 2] = ((i + t) % 2 == 0) ? 2'b01 : 2'b10;
        default: w[2*i +: 2] = 2'($urandom % 4);
      endcase
    case (mode)
      0: w[2*NI] = 1'b1;
      2: w[2*NI] = 1'b0;
      3: w[2*NI] = (t != 0);
      default: w[2*NI] = ($urandom % 4) != 0;
    endcase
    return w;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor state
  int pcnt [NT][NI];
  logic [1:0] pce = 2'b11, pfe = 2'b11;
  logic [2*NI-1:0] pin = '1;
  int ref_t, fer_t, ce_t, ce_end_t, last_key, rd_next, done_cnt;
  int e6, e7, e8, e3;

  always @(negedge clk) begin
    int nl, li, key;
    cyc++;
    if (cyc > WDOG && !wd) begin
      wd = 1;
      check(0, "WDOG", "watchdog expired cycles", cyc, WDOG);
    end
    if (rst_n && busy) begin
      nl = 0; li = 0;
      for (int i = 0; i < NI; i++) begin
        if (in_drv[2*i +: 2] == 2'b00) begin nl++; li = i; end
        if (pin[2*i +: 2] == 2'b10 && in_drv[2*i +: 2] == 2'b00) begin
          key = int'(term_sel) * NI + i;
          if (key <= last_key) e6++;
          last_key = key;
          ref_t = cyc;
        end
        if (pin[2*i +: 2] == 2'b00 && in_drv[2*i +: 2] == 2'b10)
          if (!(pfe == 2'b01 && fe_drv == 2'b00)) e6++;
      end
      if (nl > 1) e6++;
      if (pfe == 2'b00 && fe_drv == 2'b01) begin
        if (cyc - ref_t != TD) e7++;
        fer_t = cyc;
      end
      if (pce == 2'b01 && ce_drv == 2'b10) begin
        if (cyc - fer_t != TD) e7++;
        ce_t = cyc;
        if (nl != 1) e6++;
        else pcnt[term_sel][li]++;
      end
      if (pce == 2'b10 && ce_drv == 2'b01) begin
        if (cyc - ce_t != TP) e7++;
        ce_end_t = cyc;
      end
      if (pfe == 2'b01 && fe_drv == 2'b00) begin
        if (cyc - ce_end_t != TD) e7++;
        ref_t = cyc;
      end
      if (!(ce_drv == 2'b01 || ce_drv == 2'b10)) e8++;
      if (!(fe_drv == 2'b00 || fe_drv == 2'b01)) e8++;
      if (ce_drv == 2'b10 && fe_drv != 2'b01) e8++;
    end
    if (rst_n && pat_rd) begin
      if (int'(pat_addr) != rd_next) e3++;
      rd_next++;
    end
    if (rst_n && done) done_cnt++;
    pce = ce_drv; pfe = fe_drv; pin = in_drv;
  end

  task automatic run_job(int mode, bit inject);
    int k, bad4, bad5;
    for (int t = 0; t < NT; t++) begin
      mem[t] = gen_word(mode, t);
      for (int i = 0; i < NI; i++) pcnt[t][i] = 0;
    end
    e3 = 0; e6 = 0; e7 = 0; e8 = 0;
    rd_next = 0; last_key = -1; done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy && supply_en && ce_drv == 2'b01 && fe_drv == 2'b00 &&
          in_drv == {NI{2'b10}}, "R2", "armed state after start", int'(busy), 1);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (inject && k == 300) start = 1'b1;
      if (inject && k == 301) start = 1'b0;
    end while (!done && !wd);
    check(!busy && in_drv == '1 && ce_drv == 2'b11 && fe_drv == 2'b11 && !supply_en,
          "R9", "released at done", int'(busy), 0);
    @(negedge clk);
    check(!done, "R9", "done width", int'(done), 0);
    check(done_cnt == 1, "R10", "done pulses per job", done_cnt, 1);
    check(e3 == 0 && rd_next == NT, "R3", "pattern reads in order", rd_next, NT);
    bad4 = 0; bad5 = 0;
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < NI; i++)
        if (pcnt[t][i] != exp_blows(mem[t], i)) begin
          if (mem[t][2*NI]) bad5++; else bad4++;
        end
    check(bad4 == 0, "R4", "pulses on unused terms", bad4, 0);
    check(bad5 == 0, "R5", "mismatched burn counts", bad5, 0);
    check(e6 == 0, "R6", "input order errors", e6, 0);
    check(e7 == 0, "R7", "timing errors", e7, 0);
    check(e8 == 0, "R8", "bad ce/fe codes", e8, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !supply_en && in_drv == '1 && ce_drv == 2'b11 &&
          fe_drv == 2'b11, "R1", "reset state", int'(busy), 0);
    run_job(0, 0);
    if (!wd) run_job(1, 1);
    if (!wd) run_job(2, 0);
    if (!wd) run_job(3, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule